// File: doc/BRIEF.md
# Line-Driver Control Register Interface

This block is the digital control core of a four-line power driver. A host reaches it through a 4-bit register port. The port has an active-low chip select, active-low read and write strobes, one address bit and a 4-bit data path. The data path is split into an input bus, an output bus and an output-enable, which the pad ring combines into one bidirectional bus. The host can write two registers: a line enable register and an indirect pointer register. Each status register is read through the pointer.

For every line the block takes a current-overload flag and a thermal-overload flag. It drives one enable output per line and an active-low interrupt.

- A thermal event on an enabled line latches. It switches that line off until software re-arms the line.
- The interrupt follows the overload register live. It is not latched.
- The interrupt releases as soon as the offending line is switched off, whether software or thermal shutdown switches it off.

All state changes on the rising clock edge and uses a synchronous active-high reset.

Top module: `lctl_regif`

## Requirements
- R1: A write cycle (cs_n=0, wr_n=0) with addr=1 loads din into the line enable register on the next rising edge.
- R2: A write cycle with addr=0 loads din[2:0] into the pointer register, where bits [1:0] select a status register and bit 2 is the interrupt mask. A read cycle with addr=0 returns {thermal_any, pointer[2:0]}, where D3 is the OR of all latched thermal flags.
- R3: A read cycle with addr=1 returns the register chosen by pointer bits [1:0]: 0 is the overload register, 1 is the line enable register, 2 is the latched thermal flags (bit i = line i), and 3 reads as 0000.
- R4: With cs_n=1, the strobes have no effect. No register changes and dout_oe stays 0.
- R5: dout_oe is 1 exactly while cs_n=0 and rd_n=0, and dout is 0000 whenever dout_oe is 0.
- R6: drv_en[i] equals line enable bit i AND NOT latched thermal flag i, updated on the same edge as the register write.
- R7: thermal_in[i]=1 while line i is enabled sets thermal flag i at the next edge. drv_en[i] falls on that edge and stays low after thermal_in[i] returns to 0.
- R8: A thermal flag clears only by reset or by a write that moves its line enable bit from 0 to 1. Rewriting a 1 leaves it set.
- R9: Overload register bit i is the registered value of ovl_in[i] AND the line's effective enable, so a disabled line never reports an overload.
- R10: irq_n is 0 exactly when the overload register is non-zero and the mask bit is 0. It is not latched: it returns to 1 on the edge after the overloads clear.
- R11: irq_n returns to 1 on the edge where the only overloaded line is disabled, either by a line enable write or by thermal shutdown.
- R12: Reset clears all registers, drives drv_en to 0000 and holds irq_n at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 1 | Register address bit |
| din | input | 4 | Write data from host |
| dout | output | 4 | Read data to host |
| dout_oe | output | 1 | Output enable for the data bus |
| ovl_in | input | 4 | Per-line current overload flags |
| therm_in | input | 4 | Per-line thermal overload flags |
| drv_en | output | 4 | Per-line driver enables |
| irq_n | output | 1 | Overload interrupt, active low |

## Verification
The enable path is tried with mixed patterns (1011, 1010, 1111). These separate per-bit gating from whole-register behaviour. Overloads are applied to all lines at once and then to a single line. The all-lines case shows that disabled lines are filtered out of the overload register. The single-line case shows that the interrupt follows the register and is not a sticky latch.

The thermal sequence sets a flag and removes the stimulus, so the flag must persist. It then rewrites an enable bit that is already 1, which must not clear the flag, and finally performs a true 0-to-1 re-arm, which must clear it. Accesses with chip select high check that stray strobes change nothing.

// File: rtl/lctl_pkg.sv
package lctl_pkg;
  typedef enum logic [1:0] {
    SEL_OVL   = 2'd0,
    SEL_ENA   = 2'd1,
    SEL_THERM = 2'd2,
    SEL_NONE  = 2'd3
  } sel_t;

  localparam int PTR_W   = 3;
  localparam int MASK_B  = 2;
endpackage

// File: rtl/lctl_bus_dec.sv
module lctl_bus_dec (
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic addr,
  output logic wr_ena,
  output logic wr_ptr,
  output logic rd_act
);
  logic sel;
  assign sel    = ~cs_n;
  assign wr_ena = sel & ~wr_n & addr;
  assign wr_ptr = sel & ~wr_n & ~addr;
  assign rd_act = sel & ~rd_n;

  // R4
  always_comb begin
    no_access_unselected_chk: assert (!(cs_n && (wr_ena || wr_ptr || rd_act)));
  end
endmodule

// File: rtl/lctl_line.sv
module lctl_line (
  input  logic clk,
  input  logic rst,
  input  logic wr_ena,
  input  logic wr_bit,
  input  logic ovl,
  input  logic therm,
  output logic ena_q,
  output logic therm_q,
  output logic drv_q,
  output logic cod_q,
  output logic cod_nxt
);
  logic ena_nxt, therm_nxt, rearm, eff_nxt;

  assign rearm     = wr_ena & wr_bit & ~ena_q;
  assign ena_nxt   = wr_ena ? wr_bit : ena_q;
  assign therm_nxt = rearm ? 1'b0 : (therm_q | (therm & ena_nxt));
  assign eff_nxt   = ena_nxt & ~therm_nxt;
  assign cod_nxt   = ovl & eff_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q   <= 1'b0;
      therm_q <= 1'b0;
      drv_q   <= 1'b0;
      cod_q   <= 1'b0;
    end else begin
      ena_q   <= ena_nxt;
      therm_q <= therm_nxt;
      drv_q   <= eff_nxt;
      cod_q   <= cod_nxt;
    end
  end

  // R7
  therm_shutdown_chk: assert property (@(posedge clk) disable iff (rst)
    (therm && ena_q && !wr_ena) |=> !drv_q);
  // R8
  therm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (therm_q && !(wr_ena && wr_bit && !ena_q)) |=> therm_q);
  // R9
  cod_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    cod_q |-> drv_q);
endmodule

// File: rtl/lctl_rdmux.sv
module lctl_rdmux
  import lctl_pkg::*;
#(
  parameter int N_LINES = 4
) (
  input  logic               rd_act,
  input  logic               addr,
  input  logic [PTR_W-1:0]   ptr,
  input  logic [N_LINES-1:0] cod,
  input  logic [N_LINES-1:0] ena,
  input  logic [N_LINES-1:0] therm,
  output logic [N_LINES-1:0] dout,
  output logic               dout_oe
);
  logic [N_LINES-1:0] ind;
  logic [N_LINES-1:0] dir;

  always_comb begin
    unique case (sel_t'(ptr[1:0]))
      SEL_OVL:   ind = cod;
      SEL_ENA:   ind = ena;
      SEL_THERM: ind = therm;
      default:   ind = '0;
    endcase
  end

  always_comb begin
    dir = '0;
    dir[PTR_W-1:0]   = ptr;
    dir[N_LINES-1]   = |therm;
  end

  assign dout_oe = rd_act;
  assign dout    = rd_act ? (addr ? ind : dir) : '0;

  // R5
  always_comb begin
    idle_bus_zero_chk: assert (dout_oe || dout == '0);
  end
endmodule

// File: rtl/lctl_regif.sv
module lctl_regif
  import lctl_pkg::*;
#(
  parameter int N_LINES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               addr,
  input  logic [N_LINES-1:0] din,
  output logic [N_LINES-1:0] dout,
  output logic               dout_oe,
  input  logic [N_LINES-1:0] ovl_in,
  input  logic [N_LINES-1:0] therm_in,
  output logic [N_LINES-1:0] drv_en,
  output logic               irq_n
);
  logic wr_ena, wr_ptr, rd_act;
  logic [PTR_W-1:0]   ptr_q, ptr_nxt;
  logic [N_LINES-1:0] ena_q, therm_q, cod_q, cod_nxt;
  logic               irq_q;

  lctl_bus_dec u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wr_ena(wr_ena), .wr_ptr(wr_ptr), .rd_act(rd_act)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    lctl_line u_line (
      .clk(clk), .rst(rst), .wr_ena(wr_ena), .wr_bit(din[i]),
      .ovl(ovl_in[i]), .therm(therm_in[i]),
      .ena_q(ena_q[i]), .therm_q(therm_q[i]), .drv_q(drv_en[i]),
      .cod_q(cod_q[i]), .cod_nxt(cod_nxt[i])
    );
  end

  assign ptr_nxt = wr_ptr ? din[PTR_W-1:0] : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      irq_q <= 1'b1;
    end else begin
      ptr_q <= ptr_nxt;
      irq_q <= ~((|cod_nxt) & ~ptr_nxt[MASK_B]);
    end
  end
  assign irq_n = irq_q;

  lctl_rdmux #(.N_LINES(N_LINES)) u_rd (
    .rd_act(rd_act), .addr(addr), .ptr(ptr_q), .cod(cod_q),
    .ena(ena_q), .therm(therm_q), .dout(dout), .dout_oe(dout_oe)
  );

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> ((|cod_q) && !ptr_q[MASK_B]));
  // R1
  ena_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ena |=> ena_q == $past(din));
  // R12
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (irq_n && drv_en == '0));
endmodule

// File: tb/lctl_regif_bench.sv
module lctl_regif_bench;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
  logic [N-1:0] din = '0, ovl_in = '0, therm_in = '0;
  logic [N-1:0] dout, drv_en;
  logic dout_oe, irq_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lctl_regif #(.N_LINES(N)) u_lctl_regif (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .ovl_in(ovl_in), .therm_in(therm_in), .drv_en(drv_en), .irq_n(irq_n)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [N-1:0] d);
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(logic a, output logic [N-1:0] d, output logic oe);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = a;
    #1; d = dout; oe = dout_oe;
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic t_reset();
    logic [N-1:0] d; logic oe;
    chk("R12 drv_en", drv_en, 4'b0000);
    chk("R12 irq_n", {3'b0, irq_n}, 4'b0001);
    chk("R5 idle oe", {3'b0, dout_oe}, 4'b0000);
    chk("R5 idle dout", dout, 4'b0000);
    rd(0, d, oe);
    chk("R12 ptr read", d, 4'b0000);
    chk("R5 oe on read", {3'b0, oe}, 4'b0001);
  endtask

  task automatic t_enable();
    logic [N-1:0] d; logic oe;
    wr(1, 4'b1011);
    chk("R6 drv_en", drv_en, 4'b1011);
    wr(0, 4'b0001);
    rd(1, d, oe);
    chk("R1/R3 ena readback", d, 4'b1011);
    rd(0, d, oe);
    chk("R2 ptr read", d, 4'b0001);
  endtask

  task automatic t_unselected();
    logic [N-1:0] d; logic oe;
    @(negedge clk);
    wr_n = 0; addr = 1; din = 4'b0000; rd_n = 0;
    #1;
    chk("R4 oe with cs high", {3'b0, dout_oe}, 4'b0000);
    chk("R5 dout with cs high", dout, 4'b0000);
    @(negedge clk);
    wr_n = 1; rd_n = 1;
    chk("R4 drv unchanged", drv_en, 4'b1011);
    rd(1, d, oe);
    chk("R4 ena unchanged", d, 4'b1011);
  endtask

  task automatic t_overload();
    logic [N-1:0] d; logic oe;
    wr(0, 4'b0000);
    @(negedge clk); ovl_in = 4'b1111;
    @(negedge clk);
    chk("R10 irq on overload", {3'b0, irq_n}, 4'b0000);
    rd(1, d, oe);
    chk("R9 cod gated", d, 4'b1011);
    wr(0, 4'b0100);
    chk("R10 masked irq", {3'b0, irq_n}, 4'b0001);
    rd(0, d, oe);
    chk("R2 mask readback", d, 4'b0100);
    wr(0, 4'b0000);
    chk("R10 unmasked irq", {3'b0, irq_n}, 4'b0000);
    @(negedge clk); ovl_in = 4'b0000;
    @(negedge clk);
    chk("R10 unlatched release", {3'b0, irq_n}, 4'b0001);
  endtask

  task automatic t_sw_disable();
    @(negedge clk); ovl_in = 4'b0001;
    @(negedge clk);
    chk("R10 single line irq", {3'b0, irq_n}, 4'b0000);
    wr(1, 4'b1010);
    chk("R11 sw disable irq", {3'b0, irq_n}, 4'b0001);
    chk("R6 drv after disable", drv_en, 4'b1010);
    @(negedge clk); ovl_in = 4'b0000;
  endtask

  task automatic t_thermal();
    logic [N-1:0] d; logic oe;
    wr(1, 4'b1111);
    @(negedge clk); ovl_in = 4'b0100;
    @(negedge clk);
    chk("R10 irq line2", {3'b0, irq_n}, 4'b0000);
    therm_in = 4'b0100;
    @(negedge clk);
    chk("R7 drv off", drv_en, 4'b1011);
    chk("R11 thermal release", {3'b0, irq_n}, 4'b0001);
    therm_in = 4'b0000;
    @(negedge clk);
    chk("R7 stays off", drv_en, 4'b1011);
    rd(0, d, oe);
    chk("R2 thermal_any", d, 4'b1000);
    wr(0, 4'b0010);
    rd(1, d, oe);
    chk("R3 thermal sel", d, 4'b0100);
    wr(1, 4'b1111);
    chk("R8 rewrite keeps", drv_en, 4'b1011);
    wr(1, 4'b1011);
    wr(1, 4'b1111);
    chk("R8 rearm clears", drv_en, 4'b1111);
    wr(0, 4'b0011);
    rd(1, d, oe);
    chk("R3 sel3 zero", d, 4'b0000);
    @(negedge clk); ovl_in = 4'b0000;
  endtask

  task automatic t_reset_again();
    @(negedge clk); ovl_in = 4'b0001; rst = 1;
    @(negedge clk); rst = 0;
    chk("R12 drv cleared", drv_en, 4'b0000);
    chk("R12 irq high", {3'b0, irq_n}, 4'b0001);
    @(negedge clk);
    chk("R9 disabled no irq", {3'b0, irq_n}, 4'b0001);
    ovl_in = 4'b0000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_enable();
    t_unselected();
    t_overload();
    t_sw_disable();
    t_thermal();
    t_reset_again();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule